// File: doc/BRIEF.md
# Indirect Pointer Address Generator

This block works out the data-memory address for loads and stores that go through a 16-bit pointer. It also works out the new pointer value that the access leaves behind. Four 16-bit register pairs feed it from the register file: three pointers (X, Y, Z) and one general word pair (W). Each request names a pair, a mode, a 6-bit displacement and a 6-bit word immediate. The memory modes are plain, post-increment, pre-decrement and displacement. The block can also add a small immediate to any pair, or subtract one from it, and it raises the arithmetic flags for those two word operations.

Every operation takes two cycles. The cycle after a request presents the memory address. The cycle after that presents the pointer write-back and the flags. The pre-decrement mode lowers the pointer before the access and uses the lowered value as the address. The post-increment mode uses the old value as the address and raises the pointer afterwards. A new request may be issued in every cycle. If it names a pair whose write-back is still in flight, the in-flight value is forwarded to it, so back-to-back pointer walks see every update.

Top module: `ptr_addr_gen`

## Requirements
- R1: After reset, and before any request, mem_valid, req_err, wb_en and flag_we are all low.
- R2: Operation codes are 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement, 4 word add, 5 word subtract; codes 6 and 7 are rejected. In plain mode mem_addr equals the pointer one cycle after the request (mem_valid high), and there is no write-back.
- R3: Post-increment: mem_addr is the old pointer one cycle after the request. Two cycles after the request, wb_en is high and wb_value is the old pointer plus 1, wrapping from 0xFFFF to 0x0000.
- R4: Pre-decrement: mem_addr is the old pointer minus 1, and two cycles after the request that same value is written back. The value wraps from 0x0000 to 0xFFFF.
- R5: Displacement: mem_addr is the pointer plus the unsigned 6-bit displacement, modulo 2^16. The pointer is not written back.
- R6: Pair select codes are 0 W, 1 X, 2 Y, 3 Z. A memory mode on W, displacement on X, or codes 6 and 7 give req_err one cycle after the request. No memory access follows, no write-back follows, and the pair keeps its value.
- R7: Word add: two cycles after the request, wb_value is the pair plus the unsigned 6-bit immediate, modulo 2^16, with flag_we high. Flags bits are 0 C (carry out of bit 15), 1 Z (result zero), 2 N (result bit 15), 3 V (signed overflow), 4 S (N xor V).
- R8: Word subtract: as R7 with the immediate subtracted; C is the borrow out of bit 15.
- R9: A request that names a pair whose write-back from either of the two previous requests is still pending uses the newest pending value instead of the register file input.
- R10: wb_sel carries the pair of the request being written back, and flag_we is high only for word operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one per cycle |
| req_op | input | 3 | Operation code |
| req_sel | input | 2 | Pair select |
| req_disp | input | 6 | Unsigned displacement |
| req_imm | input | 6 | Unsigned word immediate |
| pair_w_in | input | 16 | Current value of pair W |
| ptr_x_in | input | 16 | Current value of pointer X |
| ptr_y_in | input | 16 | Current value of pointer Y |
| ptr_z_in | input | 16 | Current value of pointer Z |
| mem_valid | output | 1 | Memory access this cycle |
| mem_addr | output | 16 | Effective memory address |
| req_err | output | 1 | Illegal request rejected |
| wb_en | output | 1 | Pair write-back enable |
| wb_sel | output | 2 | Pair being written back |
| wb_value | output | 16 | New pair value |
| flag_we | output | 1 | Flags valid for update |
| flags | output | 5 | {S,V,N,Z,C} |

## Verification
The write-back of one request and the operand fetch of the next land in the same cycle when two requests to the same pair are issued on consecutive cycles. The bench provokes this with a chain of post-increment, post-increment, pre-decrement and plain requests on X, and with two word adds on W. The register file model updates only on wb_en, so any stale operand shows up at once. Every address and write-back value in the chain is compared against a walk of the pointer worked out in advance.

// File: rtl/ptr_addr_gen_pkg.sv
package ptr_addr_gen_pkg;

  typedef enum logic [2:0] {
    OP_PLAIN   = 3'd0,
    OP_POSTINC = 3'd1,
    OP_PREDEC  = 3'd2,
    OP_DISP    = 3'd3,
    OP_WADD    = 3'd4,
    OP_WSUB    = 3'd5
  } agu_op_e;

  localparam logic [1:0] SEL_W = 2'd0;
  localparam logic [1:0] SEL_X = 2'd1;
  localparam logic [1:0] SEL_Y = 2'd2;
  localparam logic [1:0] SEL_Z = 2'd3;

  localparam int NUM_PAIRS = 4;
  localparam int NUM_FLAGS = 5;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;

endpackage

// File: rtl/ptr_fwd_mux.sv
module ptr_fwd_mux
  import ptr_addr_gen_pkg::*;
#(
  parameter int AW = 16,
  parameter int NP = NUM_PAIRS,
  localparam int SW = $clog2(NP)
) (
  input  logic [NP-1:0][AW-1:0] rf_i,
  input  logic [SW-1:0]         sel_i,
  input  logic                  near_hit_en_i,
  input  logic [SW-1:0]         near_sel_i,
  input  logic [AW-1:0]         near_val_i,
  input  logic                  far_hit_en_i,
  input  logic [SW-1:0]         far_sel_i,
  input  logic [AW-1:0]         far_val_i,
  output logic [AW-1:0]         opd_o
);

  logic [NP-1:0][AW-1:0] fwd_val;

  for (genvar gi = 0; gi < NP; gi++) begin : g_pair
    always_comb begin
      if (near_hit_en_i && (near_sel_i == SW'(gi))) begin
        fwd_val[gi] = near_val_i;
      end else if (far_hit_en_i && (far_sel_i == SW'(gi))) begin
        fwd_val[gi] = far_val_i;
      end else begin
        fwd_val[gi] = rf_i[gi];
      end
    end
  end

  assign opd_o = fwd_val[sel_i];

endmodule

// File: rtl/ptr_addr_calc.sv
module ptr_addr_calc
  import ptr_addr_gen_pkg::*;
#(
  parameter int AW = 16,
  parameter int QW = 6,
  parameter int IW = 6
) (
  input  logic [2:0]           op_i,
  input  logic [1:0]           sel_i,
  input  logic [AW-1:0]        opd_i,
  input  logic [QW-1:0]        disp_i,
  input  logic [IW-1:0]        imm_i,
  output logic                 legal_o,
  output logic                 is_mem_o,
  output logic [AW-1:0]        addr_o,
  output logic                 upd_o,
  output logic [AW-1:0]        new_o,
  output logic                 fwe_o,
  output logic [NUM_FLAGS-1:0] flags_o
);

  logic [AW:0]  sum_w;
  logic [AW:0]  dif_w;
  logic [AW-1:0] disp_ext;
  logic         legal_c;
  logic         upd_c;

  assign disp_ext = {{(AW-QW){1'b0}}, disp_i};
  assign sum_w    = {1'b0, opd_i} + {{(AW+1-IW){1'b0}}, imm_i};
  assign dif_w    = {1'b0, opd_i} - {{(AW+1-IW){1'b0}}, imm_i};

  always_comb begin
    legal_c  = 1'b0;
    is_mem_o = 1'b0;
    addr_o   = opd_i;
    upd_c    = 1'b0;
    new_o    = opd_i;
    fwe_o    = 1'b0;
    flags_o  = '0;
    case (op_i)
      OP_PLAIN: begin
        is_mem_o = 1'b1;
        legal_c  = (sel_i != SEL_W);
      end
      OP_POSTINC: begin
        is_mem_o = 1'b1;
        legal_c  = (sel_i != SEL_W);
        upd_c    = 1'b1;
        new_o    = opd_i + AW'(1);
      end
      OP_PREDEC: begin
        is_mem_o = 1'b1;
        legal_c  = (sel_i != SEL_W);
        upd_c    = 1'b1;
        new_o    = opd_i - AW'(1);
        addr_o   = opd_i - AW'(1);
      end
      OP_DISP: begin
        is_mem_o = 1'b1;
        legal_c  = (sel_i == SEL_Y) || (sel_i == SEL_Z);
        addr_o   = opd_i + disp_ext;
      end
      OP_WADD: begin
        legal_c        = 1'b1;
        upd_c          = 1'b1;
        fwe_o          = 1'b1;
        new_o          = sum_w[AW-1:0];
        flags_o[FL_C]  = sum_w[AW];
        flags_o[FL_V]  = ~opd_i[AW-1] & sum_w[AW-1];
      end
      OP_WSUB: begin
        legal_c        = 1'b1;
        upd_c          = 1'b1;
        fwe_o          = 1'b1;
        new_o          = dif_w[AW-1:0];
        flags_o[FL_C]  = dif_w[AW];
        flags_o[FL_V]  = opd_i[AW-1] & ~dif_w[AW-1];
      end
      default: begin
        legal_c = 1'b0;
      end
    endcase
    if (fwe_o) begin
      flags_o[FL_Z] = (new_o == '0);
      flags_o[FL_N] = new_o[AW-1];
      flags_o[FL_S] = new_o[AW-1] ^ flags_o[FL_V];
    end
  end

  assign legal_o = legal_c;
  assign upd_o   = legal_c & upd_c;

endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import ptr_addr_gen_pkg::*;
#(
  parameter int AW = 16,
  parameter int QW = 6,
  parameter int IW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [2:0]           req_op,
  input  logic [1:0]           req_sel,
  input  logic [QW-1:0]        req_disp,
  input  logic [IW-1:0]        req_imm,
  input  logic [AW-1:0]        pair_w_in,
  input  logic [AW-1:0]        ptr_x_in,
  input  logic [AW-1:0]        ptr_y_in,
  input  logic [AW-1:0]        ptr_z_in,
  output logic                 mem_valid,
  output logic [AW-1:0]        mem_addr,
  output logic                 req_err,
  output logic                 wb_en,
  output logic [1:0]           wb_sel,
  output logic [AW-1:0]        wb_value,
  output logic                 flag_we,
  output logic [NUM_FLAGS-1:0] flags
);

  // stage 1: access cycle
  logic                 s1_valid_q, s1_valid_d;
  logic                 s1_err_q,   s1_err_d;
  logic                 s1_ld;
  logic                 s1_mem_q;
  logic [AW-1:0]        s1_addr_q;
  logic                 s1_upd_q;
  logic [1:0]           s1_sel_q;
  logic [AW-1:0]        s1_val_q;
  logic                 s1_fwe_q;
  logic [NUM_FLAGS-1:0] s1_flags_q;

  // stage 2: write-back cycle
  logic                 s2_wb_q,  s2_wb_d;
  logic                 s2_fwe_q, s2_fwe_d;
  logic                 s2_ld;
  logic [1:0]           s2_sel_q;
  logic [AW-1:0]        s2_val_q;
  logic [NUM_FLAGS-1:0] s2_flags_q;

  // combinational results for the incoming request
  logic [NUM_PAIRS-1:0][AW-1:0] rf_vec;
  logic [AW-1:0]        opd;
  logic                 c_legal;
  logic                 c_mem;
  logic [AW-1:0]        c_addr;
  logic                 c_upd;
  logic [AW-1:0]        c_new;
  logic                 c_fwe;
  logic [NUM_FLAGS-1:0] c_flags;

  assign rf_vec[SEL_W] = pair_w_in;
  assign rf_vec[SEL_X] = ptr_x_in;
  assign rf_vec[SEL_Y] = ptr_y_in;
  assign rf_vec[SEL_Z] = ptr_z_in;

  ptr_fwd_mux #(.AW(AW), .NP(NUM_PAIRS)) u_fwd (
    .rf_i          (rf_vec),
    .sel_i         (req_sel),
    .near_hit_en_i (s1_valid_q & s1_upd_q),
    .near_sel_i    (s1_sel_q),
    .near_val_i    (s1_val_q),
    .far_hit_en_i  (s2_wb_q),
    .far_sel_i     (s2_sel_q),
    .far_val_i     (s2_val_q),
    .opd_o         (opd)
  );

  ptr_addr_calc #(.AW(AW), .QW(QW), .IW(IW)) u_calc (
    .op_i     (req_op),
    .sel_i    (req_sel),
    .opd_i    (opd),
    .disp_i   (req_disp),
    .imm_i    (req_imm),
    .legal_o  (c_legal),
    .is_mem_o (c_mem),
    .addr_o   (c_addr),
    .upd_o    (c_upd),
    .new_o    (c_new),
    .fwe_o    (c_fwe),
    .flags_o  (c_flags)
  );

  // next-state logic
  always_comb begin
    s1_ld      = req_valid;
    s1_valid_d = req_valid & c_legal;
    s1_err_d   = req_valid & ~c_legal;
    s2_ld      = s1_valid_q;
    s2_wb_d    = s1_valid_q & s1_upd_q;
    s2_fwe_d   = s1_valid_q & s1_fwe_q;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_err_q   <= 1'b0;
      s2_wb_q    <= 1'b0;
      s2_fwe_q   <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_err_q   <= s1_err_d;
      s2_wb_q    <= s2_wb_d;
      s2_fwe_q   <= s2_fwe_d;
    end
  end

  // datapath registers, loaded under clock enable
  always_ff @(posedge clk) begin
    if (s1_ld) begin
      s1_mem_q   <= c_mem;
      s1_addr_q  <= c_addr;
      s1_upd_q   <= c_upd;
      s1_sel_q   <= req_sel;
      s1_val_q   <= c_new;
      s1_fwe_q   <= c_fwe;
      s1_flags_q <= c_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_ld) begin
      s2_sel_q   <= s1_sel_q;
      s2_val_q   <= s1_val_q;
      s2_flags_q <= s1_flags_q;
    end
  end

  assign mem_valid = s1_valid_q & s1_mem_q;
  assign mem_addr  = s1_addr_q;
  assign req_err   = s1_err_q;
  assign wb_en     = s2_wb_q;
  assign wb_sel    = s2_sel_q;
  assign wb_value  = s2_val_q;
  assign flag_we   = s2_fwe_q;
  assign flags     = s2_flags_q;

endmodule

// File: rtl/ptr_addr_gen_chk.sv
module ptr_addr_gen_chk #(
  parameter int AW = 16,
  parameter int QW = 6,
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    req_op,
  input logic [1:0]    req_sel,
  input logic [QW-1:0] req_disp,
  input logic [IW-1:0] req_imm,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr,
  input logic          req_err,
  input logic          wb_en,
  input logic [AW-1:0] wb_value,
  input logic          flag_we,
  input logic [4:0]    flags
);

  AST_PLAIN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd0 && req_sel != 2'd0) |=> mem_valid); // R2

  AST_POSTINC_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd1 && req_sel != 2'd0)
      |=> ##1 (wb_en && wb_value == $past(mem_addr) + AW'(1))); // R3

  AST_PREDEC_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2 && req_sel != 2'd0)
      |=> ##1 (wb_en && wb_value == $past(mem_addr))); // R4

  AST_DISP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3 && req_sel[1]) |=> ##1 !wb_en); // R5

  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !mem_valid); // R6

  AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> !wb_en); // R6

  AST_FLAGS_WITH_WB: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> wb_en); // R10

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (flags[1] == (wb_value == '0))); // R7

endmodule

bind ptr_addr_gen ptr_addr_gen_chk #(.AW(AW), .QW(QW), .IW(IW)) u_chk (.*);

// File: tb/ptr_addr_gen_tb.sv
module ptr_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [1:0]  req_sel = '0;
  logic [5:0]  req_disp = '0;
  logic [5:0]  req_imm = '0;
  logic        mem_valid, req_err, wb_en, flag_we;
  logic [15:0] mem_addr, wb_value;
  logic [1:0]  wb_sel;
  logic [4:0]  flags;

  logic [15:0] rf [4];
  logic        pre_en = 1'b0;
  logic [1:0]  pre_idx = '0;
  logic [15:0] pre_val = '0;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // captured results of one operation
  logic        g_mv, g_err, g_wb, g_fwe;
  logic [15:0] g_addr, g_wval;
  logic [1:0]  g_wsel;
  logic [4:0]  g_fl;

  always #2 clk = ~clk;

  // register file model: preload from tasks, otherwise write-back
  always @(posedge clk) begin
    if (pre_en) rf[pre_idx] <= pre_val;
    else if (wb_en) rf[wb_sel] <= wb_value;
  end

  ptr_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_sel(req_sel), .req_disp(req_disp), .req_imm(req_imm),
    .pair_w_in(rf[0]), .ptr_x_in(rf[1]), .ptr_y_in(rf[2]), .ptr_z_in(rf[3]),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .req_err(req_err),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value),
    .flag_we(flag_we), .flags(flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [1:0] idx, input logic [15:0] val);
    @(negedge clk);
    pre_en = 1'b1; pre_idx = idx; pre_val = val;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic do_op(input logic [2:0] op, input logic [1:0] sel,
                       input logic [5:0] q, input logic [5:0] k);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_sel = sel; req_disp = q; req_imm = k;
    @(negedge clk);
    req_valid = 1'b0;
    g_mv = mem_valid; g_addr = mem_addr; g_err = req_err;
    @(negedge clk);
    g_wb = wb_en; g_wsel = wb_sel; g_wval = wb_value; g_fwe = flag_we; g_fl = flags;
  endtask

  task automatic t_reset();
    chk("R1 mem_valid", {31'b0, mem_valid}, 0);
    chk("R1 req_err",   {31'b0, req_err},   0);
    chk("R1 wb_en",     {31'b0, wb_en},     0);
    chk("R1 flag_we",   {31'b0, flag_we},   0);
  endtask

  task automatic t_plain();
    preload(2'd2, 16'h4321);
    do_op(3'd0, 2'd2, 6'd0, 6'd0);
    chk("R2 plain mem_valid", {31'b0, g_mv}, 1);
    chk("R2 plain addr", {16'b0, g_addr}, 32'h4321);
    chk("R2 plain no wb", {31'b0, g_wb}, 0);
  endtask

  task automatic t_postinc();
    preload(2'd3, 16'h1234);
    do_op(3'd1, 2'd3, 6'd0, 6'd0);
    chk("R3 postinc addr", {16'b0, g_addr}, 32'h1234);
    chk("R3 postinc wb", {31'b0, g_wb}, 1);
    chk("R3 postinc value", {16'b0, g_wval}, 32'h1235);
    chk("R10 postinc sel", {30'b0, g_wsel}, 3);
    chk("R10 no flags", {31'b0, g_fwe}, 0);
    preload(2'd1, 16'hFFFF);
    do_op(3'd1, 2'd1, 6'd0, 6'd0);
    chk("R3 wrap addr", {16'b0, g_addr}, 32'hFFFF);
    chk("R3 wrap value", {16'b0, g_wval}, 32'h0000);
  endtask

  task automatic t_predec();
    preload(2'd2, 16'h0100);
    do_op(3'd2, 2'd2, 6'd0, 6'd0);
    chk("R4 predec addr", {16'b0, g_addr}, 32'h00FF);
    chk("R4 predec value", {16'b0, g_wval}, 32'h00FF);
    chk("R10 predec sel", {30'b0, g_wsel}, 2);
    preload(2'd1, 16'h0000);
    do_op(3'd2, 2'd1, 6'd0, 6'd0);
    chk("R4 wrap addr", {16'b0, g_addr}, 32'hFFFF);
    chk("R4 wrap value", {16'b0, g_wval}, 32'hFFFF);
  endtask

  task automatic t_disp();
    preload(2'd2, 16'h2000);
    do_op(3'd3, 2'd2, 6'd63, 6'd0);
    chk("R5 disp Y addr", {16'b0, g_addr}, 32'h203F);
    chk("R5 disp no wb", {31'b0, g_wb}, 0);
    preload(2'd3, 16'hFFF0);
    do_op(3'd3, 2'd3, 6'd32, 6'd0);
    chk("R5 disp Z wrap", {16'b0, g_addr}, 32'h0010);
    @(negedge clk);
    chk("R5 Z unchanged", {16'b0, rf[3]}, 32'hFFF0);
  endtask

  task automatic t_illegal();
    preload(2'd1, 16'h0AAA);
    do_op(3'd3, 2'd1, 6'd5, 6'd0);
    chk("R6 disp X err", {31'b0, g_err}, 1);
    chk("R6 disp X no access", {31'b0, g_mv}, 0);
    chk("R6 disp X no wb", {31'b0, g_wb}, 0);
    preload(2'd0, 16'h5555);
    do_op(3'd1, 2'd0, 6'd0, 6'd0);
    chk("R6 postinc W err", {31'b0, g_err}, 1);
    chk("R6 postinc W no wb", {31'b0, g_wb}, 0);
    do_op(3'd7, 2'd1, 6'd0, 6'd9);
    chk("R6 code 7 err", {31'b0, g_err}, 1);
    @(negedge clk);
    chk("R6 W kept", {16'b0, rf[0]}, 32'h5555);
    chk("R6 X kept", {16'b0, rf[1]}, 32'h0AAA);
  endtask

  task automatic t_wadd();
    preload(2'd0, 16'hFFFF);
    do_op(3'd4, 2'd0, 6'd0, 6'd1);
    chk("R7 add wrap value", {16'b0, g_wval}, 32'h0000);
    chk("R7 add flag_we", {31'b0, g_fwe}, 1);
    chk("R7 add carry zero", {27'b0, g_fl}, 32'b00011); // C=1 Z=1
    chk("R10 add sel", {30'b0, g_wsel}, 0);
    preload(2'd3, 16'h7FFF);
    do_op(3'd4, 2'd3, 6'd0, 6'd63);
    chk("R7 add overflow value", {16'b0, g_wval}, 32'h803E);
    chk("R7 add overflow flags", {27'b0, g_fl}, 32'b01100); // N=1 V=1 S=0
  endtask

  task automatic t_wsub();
    preload(2'd0, 16'h0000);
    do_op(3'd5, 2'd0, 6'd0, 6'd1);
    chk("R8 sub borrow value", {16'b0, g_wval}, 32'hFFFF);
    chk("R8 sub borrow flags", {27'b0, g_fl}, 32'b10101); // C=1 N=1 S=1
    preload(2'd1, 16'h8000);
    do_op(3'd5, 2'd1, 6'd0, 6'd1);
    chk("R8 sub overflow value", {16'b0, g_wval}, 32'h7FFF);
    chk("R8 sub overflow flags", {27'b0, g_fl}, 32'b11000); // V=1 S=1
    preload(2'd2, 16'h0005);
    do_op(3'd5, 2'd2, 6'd0, 6'd5);
    chk("R8 sub zero flags", {27'b0, g_fl}, 32'b00010);
  endtask

  // back-to-back requests on one pointer: forwarding of pending write-backs
  task automatic t_forward();
    preload(2'd1, 16'h1000);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd1; req_sel = 2'd1;          // post-inc X
    @(negedge clk);
    req_op = 3'd1;                                             // post-inc X
    chk("R9 first addr", {16'b0, mem_addr}, 32'h1000);
    @(negedge clk);
    req_op = 3'd2;                                             // pre-dec X
    chk("R9 second addr", {16'b0, mem_addr}, 32'h1001);
    chk("R9 first wb", {16'b0, wb_value}, 32'h1001);
    @(negedge clk);
    req_op = 3'd0;                                             // plain X
    chk("R9 third addr", {16'b0, mem_addr}, 32'h1001);
    chk("R9 second wb", {16'b0, wb_value}, 32'h1002);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 fourth addr", {16'b0, mem_addr}, 32'h1001);
    chk("R9 third wb", {16'b0, wb_value}, 32'h1001);
    @(negedge clk);
    chk("R9 plain no wb", {31'b0, wb_en}, 0);
    @(negedge clk);
    chk("R9 final X", {16'b0, rf[1]}, 32'h1001);
    preload(2'd0, 16'h0010);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd4; req_sel = 2'd0; req_imm = 6'd1;
    @(negedge clk);
    req_imm = 6'd2;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 word first", {16'b0, wb_value}, 32'h0011);
    @(negedge clk);
    chk("R9 word second", {16'b0, wb_value}, 32'h0013);
  endtask

  initial begin
    rf[0] = '0; rf[1] = '0; rf[2] = '0; rf[3] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_postinc();
    t_predec();
    t_disp();
    t_illegal();
    t_wadd();
    t_wsub();
    t_forward();
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule